// File: doc/BRIEF.md
# Move-Only Transport-Triggered Processor Core

This core executes a program in which every instruction is a single transfer: a 32-bit instruction word holds a source address in its upper 16 bits and a destination address in its lower 16 bits. The core copies the value read at the source to the destination, one transfer per clock. The instruction word has no operation field. Arithmetic, conditional selection, jumps and subroutine calls happen because particular addresses in a mapped function window are read or written.

The function window is the 256-address block starting at `MAP_BASE`, which defaults to 0xFF00. Only its first sixteen offsets have a function. Every address outside the window goes to an external data RAM. The RAM is read asynchronously at `dmem_raddr_o` and written on the clock edge at `dmem_waddr_o`. Instructions come from an external ROM that is read asynchronously at `imem_addr_o`. A halt location stops execution. The accumulator and the return-stack error bit are brought out for observation.

Top module: `mv_core`

## Requirements
- R1: While `rst_ni` is low the following are all zero: the program counter, the accumulator, the zero and carry flags, the Z and NZ values, the return-stack count and pointer, `halt_o` and `stk_err_o`.
- R2: Each clock the core fetches the word at `imem_addr_o` (the PC). Bits 31:16 are the source address and bits 15:0 the destination. Source addresses below 0xFF00 read the RAM. A destination below 0xFF00 raises `dmem_we_o` with the read value on `dmem_wdata_o`. Unless a control location is written, the PC then advances by one.
- R3: Offset 0x00 (0xFF00) is the accumulator: a write loads it and a read returns it. Writes to 0xFF01 through 0xFF07 apply AND, OR, XOR, ADD, ADC, SUB and SBB respectively. The accumulator is the left operand and the result replaces it. A write to any of 0xFF00 through 0xFF07 sets the zero flag to (new accumulator == 0).
- R4: The carry flag receives the carry out of ADD and ADC and the borrow out of SUB and SBB. ADC adds the carry flag and SBB subtracts it. A load, AND, OR or XOR leaves the carry unchanged. A read of 0xFF0E returns the carry flag in bit 1 and the zero flag in bit 0, with the other bits zero.
- R5: 0xFF08 (Z) and 0xFF09 (NZ) each store the value written to them. A read of either address returns the stored Z value when the zero flag is 1 and the stored NZ value when it is 0.
- R6: A write to 0xFF0A loads the PC, and the next fetch is at the written value, with no delay slot. A read of 0xFF0A returns the address of the executing transfer.
- R7: A write to 0xFF0B sets the PC to the address of the executing transfer plus the written value, modulo 2^16.
- R8: A write to 0xFF0C pushes the address of the executing transfer plus one onto the return stack and jumps to the written value. A read of 0xFF0D pops the stack and returns the popped entry, so a transfer from 0xFF0D to 0xFF0A is a return.
- R9: The return stack holds 16 entries and its pointer wraps. The following set `stk_err_o`, which then stays set until reset: a push while 16 entries are held, or a pop while none are held.
- R10: A write to 0xFF0F sets `halt_o` after that edge. From then on the PC and accumulator hold and no RAM write occurs.
- R11: Reads of the write-only offsets return zero: 0x01 to 0x07, 0x0B, 0x0C, 0x0F, and 0x10 to 0xFF. Writes to 0x0D, 0x0E and 0x10 to 0xFF change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_addr_o | output | 16 | Instruction fetch address (program counter) |
| imem_data_i | input | 32 | Instruction word: source in [31:16], destination in [15:0] |
| dmem_raddr_o | output | 16 | Data RAM read address (source field) |
| dmem_rdata_i | input | 16 | Data RAM read data, combinational |
| dmem_we_o | output | 1 | Data RAM write enable |
| dmem_waddr_o | output | 16 | Data RAM write address (destination field) |
| dmem_wdata_o | output | 16 | Value being moved |
| halt_o | output | 1 | Core has executed a halt |
| acc_o | output | 16 | Accumulator contents |
| stk_err_o | output | 1 | Sticky return-stack overflow/underflow flag |

## Verification
A program-level model in the bench predicts the fetch address, the write enable and the written value for every cycle, so a single bad transfer shows up where it happens.

The targeted corner cases are these:
- ADD that carries out to a zero result, then ADC. A core with the wrong carry polarity or a stale carry gives the wrong sums.
- SUB that borrows through zero, then SBB.
- AND after a carry. A core that clears the carry on logic operations reports the wrong flags.
- Z/NZ reads in both flag states, driving taken and not-taken conditional jumps.
- A negative relative jump.
- A nested call whose return address is popped into RAM.
- The instruction just after a jump. A core with a delay slot executes it.
- Seventeen pushes followed by a pop, and a pop on an empty stack. A core that saturates instead of wrapping, or that fails to latch the error, returns the wrong entry or leaves the error low.
- Writes to dead function offsets. A core that decodes them as aliases changes the accumulator or the flags.

// File: rtl/mv_pkg.sv
package mv_pkg;
  localparam int unsigned FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_ACC, FN_AND, FN_OR, FN_XOR, FN_ADD, FN_ADC, FN_SUB, FN_SBB,
    FN_SELZ, FN_SELNZ, FN_PC, FN_REL, FN_CALL, FN_RET, FN_FLAGS, FN_HALT
  } fn_e;

  typedef enum logic [2:0] {
    OP_LOAD, OP_AND, OP_OR, OP_XOR, OP_ADD, OP_ADC, OP_SUB, OP_SBB
  } alu_op_e;
endpackage

// File: rtl/mv_addr_dec.sv
module mv_addr_dec
  import mv_pkg::*;
#(
  parameter int unsigned     DW       = 16,
  parameter logic [DW-1:0]   MAP_BASE = 16'hFF00,
  parameter int unsigned     MAP_BITS = 8
) (
  input  logic [DW-1:0] addr_i,
  output logic          map_o,
  output logic          fn_ok_o,
  output fn_e           fn_o
);
  assign map_o   = (addr_i[DW-1:MAP_BITS] == MAP_BASE[DW-1:MAP_BITS]);
  // only the low FN_W offsets of the window carry a function
  assign fn_ok_o = map_o && (addr_i[MAP_BITS-1:FN_W] == '0);
  assign fn_o    = fn_e'(addr_i[FN_W-1:0]);
endmodule

// File: rtl/mv_alu.sv
module mv_alu
  import mv_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          cout_o,
  output logic          cupd_o
);
  logic [DW:0] ext;
  logic [DW:0] a_x, b_x, c_x;

  assign a_x = {1'b0, a_i};
  assign b_x = {1'b0, b_i};
  assign c_x = {{DW{1'b0}}, cin_i};

  always_comb begin
    ext    = '0;
    res_o  = b_i;
    cupd_o = 1'b0;
    unique case (op_i)
      OP_LOAD: res_o = b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        unique case (op_i)
          OP_ADD:  ext = a_x + b_x;
          OP_ADC:  ext = a_x + b_x + c_x;
          OP_SUB:  ext = a_x - b_x;
          default: ext = a_x - b_x - c_x;
        endcase
        res_o  = ext[DW-1:0];
        cupd_o = 1'b1;
      end
      default: res_o = b_i;
    endcase
  end

  // top bit is carry for add, borrow for subtract
  assign cout_o = ext[DW];
endmodule

// File: rtl/mv_retstack.sv
module mv_retstack #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] push_data_i,
  output logic [DW-1:0] top_o,
  output logic          err_o
);
  localparam int unsigned SPW = $clog2(DEPTH);
  localparam logic [SPW:0] FULL = (SPW+1)'(DEPTH);

  logic [DW-1:0]  mem_q [DEPTH];
  logic [SPW-1:0] sp_q, sp_dn, sp_up, sp_nxt;
  logic [SPW:0]   cnt_q, cnt_pop, cnt_nxt;
  logic           err_q, err_nxt;

  assign sp_dn = sp_q - SPW'(1);
  assign sp_up = sp_q + SPW'(1);
  assign top_o = mem_q[sp_dn];
  assign err_o = err_q;

  always_comb begin
    sp_nxt = sp_q;
    if (push_i && !pop_i) sp_nxt = sp_up;
    else if (pop_i && !push_i) sp_nxt = sp_dn;
    cnt_pop = (pop_i && cnt_q != '0) ? cnt_q - (SPW+1)'(1) : cnt_q;
    cnt_nxt = (push_i && cnt_pop != FULL) ? cnt_pop + (SPW+1)'(1) : cnt_pop;
    err_nxt = err_q | (pop_i && cnt_q == '0) | (push_i && cnt_pop == FULL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      sp_q  <= sp_nxt;
      cnt_q <= cnt_nxt;
      err_q <= err_nxt;
    end
  end

  // pop+push in one move rewrites the popped slot
  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[pop_i ? sp_dn : sp_q] <= push_data_i;
  end

  assert_err_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(err_q) |-> err_q);
  assert_cnt_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  assert_push_top_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> top_o == $past(push_data_i));
endmodule

// File: rtl/mv_core.sv
module mv_core
  import mv_pkg::*;
#(
  parameter int unsigned   DW          = 16,
  parameter logic [DW-1:0] MAP_BASE    = 16'hFF00,
  parameter int unsigned   MAP_BITS    = 8,
  parameter int unsigned   STACK_DEPTH = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [DW-1:0] imem_addr_o,
  input  logic [2*DW-1:0] imem_data_i,
  output logic [DW-1:0] dmem_raddr_o,
  input  logic [DW-1:0] dmem_rdata_i,
  output logic          dmem_we_o,
  output logic [DW-1:0] dmem_waddr_o,
  output logic [DW-1:0] dmem_wdata_o,
  output logic          halt_o,
  output logic [DW-1:0] acc_o,
  output logic          stk_err_o
);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] pc_q, acc_q, zv_q, nzv_q, pc_nxt, rd_val;
  logic          z_q, c_q, halt_q, run;
  logic [DW-1:0] src_a, dst_a;
  logic          s_map, s_ok, d_map, d_ok;
  fn_e           s_fn, d_fn;
  logic [DW-1:0] alu_res, stk_top;
  logic          alu_cout, alu_cupd, alu_wr;
  logic          push, pop, d_pc, d_rel, d_selz, d_selnz, d_halt;
  alu_op_e       alu_op;

  assign src_a = imem_data_i[2*DW-1:DW];
  assign dst_a = imem_data_i[DW-1:0];
  assign run   = !halt_q;

  mv_addr_dec #(.DW(DW), .MAP_BASE(MAP_BASE), .MAP_BITS(MAP_BITS)) i_src_dec (
    .addr_i(src_a), .map_o(s_map), .fn_ok_o(s_ok), .fn_o(s_fn));
  mv_addr_dec #(.DW(DW), .MAP_BASE(MAP_BASE), .MAP_BITS(MAP_BITS)) i_dst_dec (
    .addr_i(dst_a), .map_o(d_map), .fn_ok_o(d_ok), .fn_o(d_fn));

  assign pop     = run && s_ok && (s_fn == FN_RET);
  assign push    = run && d_ok && (d_fn == FN_CALL);
  assign d_pc    = run && d_ok && (d_fn == FN_PC);
  assign d_rel   = run && d_ok && (d_fn == FN_REL);
  assign d_selz  = run && d_ok && (d_fn == FN_SELZ);
  assign d_selnz = run && d_ok && (d_fn == FN_SELNZ);
  assign d_halt  = run && d_ok && (d_fn == FN_HALT);
  assign alu_wr  = run && d_ok && (d_fn <= FN_SBB);
  assign alu_op  = alu_op_e'(d_fn[2:0]);

  // source read: RAM, or a function location
  always_comb begin
    rd_val = '0;
    if (!s_map) begin
      rd_val = dmem_rdata_i;
    end else if (s_ok) begin
      unique case (s_fn)
        FN_ACC:             rd_val = acc_q;
        FN_SELZ, FN_SELNZ:  rd_val = z_q ? zv_q : nzv_q;
        FN_PC:              rd_val = pc_q;
        FN_RET:             rd_val = stk_top;
        FN_FLAGS:           rd_val = {{(DW-2){1'b0}}, c_q, z_q};
        default:            rd_val = '0;
      endcase
    end
  end

  mv_alu #(.DW(DW)) i_alu (
    .op_i(alu_op), .a_i(acc_q), .b_i(rd_val), .cin_i(c_q),
    .res_o(alu_res), .cout_o(alu_cout), .cupd_o(alu_cupd));

  mv_retstack #(.DW(DW), .DEPTH(STACK_DEPTH)) i_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .pop_i(pop),
    .push_data_i(pc_q + ONE), .top_o(stk_top), .err_o(stk_err_o));

  always_comb begin
    if (!run)               pc_nxt = pc_q;
    else if (d_pc || push)  pc_nxt = rd_val;
    else if (d_rel)         pc_nxt = pc_q + rd_val;
    else                    pc_nxt = pc_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      acc_q  <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      zv_q   <= '0;
      nzv_q  <= '0;
      halt_q <= 1'b0;
    end else begin
      pc_q <= pc_nxt;
      if (alu_wr) begin
        acc_q <= alu_res;
        z_q   <= (alu_res == '0);
        if (alu_cupd) c_q <= alu_cout;
      end
      if (d_selz)  zv_q   <= rd_val;
      if (d_selnz) nzv_q  <= rd_val;
      if (d_halt)  halt_q <= 1'b1;
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_raddr_o = src_a;
  assign dmem_we_o    = run && !d_map;
  assign dmem_waddr_o = dst_a;
  assign dmem_wdata_o = rd_val;
  assign halt_o       = halt_q;
  assign acc_o        = acc_q;

  assert_zero_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_wr |=> z_q == (acc_o == '0));
  assert_carry_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_wr && !(alu_op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB})) |=> $stable(c_q));
  assert_jump_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_pc |=> imem_addr_o == $past(dmem_wdata_o));
  assert_rel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_rel |=> imem_addr_o == $past(imem_addr_o) + $past(dmem_wdata_o));
  assert_halt_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> $stable(imem_addr_o) && $stable(acc_o) && !dmem_we_o);
endmodule

// File: tb/test_mv_core.sv
module test_mv_core;
  localparam logic [15:0] A_ACC = 16'hFF00, A_AND = 16'hFF01, A_OR  = 16'hFF02,
                          A_XOR = 16'hFF03, A_ADD = 16'hFF04, A_ADC = 16'hFF05,
                          A_SUB = 16'hFF06, A_SBB = 16'hFF07, A_SZ  = 16'hFF08,
                          A_SNZ = 16'hFF09, A_PC  = 16'hFF0A, A_REL = 16'hFF0B,
                          A_CALL= 16'hFF0C, A_RET = 16'hFF0D, A_FLG = 16'hFF0E,
                          A_HLT = 16'hFF0F;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] imem_addr, dmem_raddr, dmem_rdata, dmem_waddr, dmem_wdata, acc;
  logic [31:0] imem_data;
  logic        dmem_we, halt, stk_err;

  logic [31:0] rom [256];
  string       rom_tag [256];
  logic [15:0] ram [256];
  logic [15:0] m_ram [256];
  logic [15:0] m_acc;
  bit          m_err;

  assign imem_data  = rom[imem_addr[7:0]];
  assign dmem_rdata = ram[dmem_raddr[7:0]];
  always @(posedge clk) if (rst_ni && dmem_we) ram[dmem_waddr[7:0]] <= dmem_wdata;

  mv_core i_mv_core (
    .clk_i(clk), .rst_ni(rst_ni), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_raddr_o(dmem_raddr), .dmem_rdata_i(dmem_rdata), .dmem_we_o(dmem_we),
    .dmem_waddr_o(dmem_waddr), .dmem_wdata_o(dmem_wdata), .halt_o(halt),
    .acc_o(acc), .stk_err_o(stk_err));

  int checks = 0, errors = 0;
  bit mon_on = 0;
  string cur_tag = "R2";
  int wp = 0;

  logic [15:0] q_pc[$], q_wa[$], q_wd[$];
  bit          q_we[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic mv(input logic [15:0] s, input logic [15:0] d);
    rom[wp] = {s, d}; rom_tag[wp] = cur_tag; wp++;
  endtask

  task automatic put(input int a, input logic [15:0] s, input logic [15:0] d);
    rom[a] = {s, d}; rom_tag[a] = cur_tag;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) begin
      rom[i] = {16'h0000, A_HLT}; rom_tag[i] = "R10";
      ram[i] = (i < 32) ? 16'(i) : 16'h0000;
    end
    ram[8'h40] = 16'h1234; ram[8'h41] = 16'h00FF; ram[8'h42] = 16'hFFFF;
    ram[8'h43] = 16'h8000; ram[8'h44] = 16'h0F0F;
    wp = 0;
  endtask

  // program-level reference: one expected item per executed transfer
  task automatic run_model();
    logic [15:0] pc = 0, acc_m = 0, zv = 0, nzv = 0, val, npc, s, d;
    logic [15:0] stk [16];
    logic [16:0] e;
    bit z = 0, c = 0, err = 0, halted = 0, we;
    int sp = 0, cnt = 0;
    for (int i = 0; i < 16; i++) stk[i] = 0;
    for (int i = 0; i < 256; i++) m_ram[i] = ram[i];
    for (int n = 0; n < 1000 && !halted; n++) begin
      s = rom[pc[7:0]][31:16]; d = rom[pc[7:0]][15:0];
      if (s[15:8] != 8'hFF) val = m_ram[s[7:0]];
      else case (s)
        A_ACC:       val = acc_m;
        A_SZ, A_SNZ: val = z ? zv : nzv;
        A_PC:        val = pc;
        A_FLG:       val = {14'b0, c, z};
        A_RET: begin
          sp = (sp + 15) % 16; val = stk[sp];
          if (cnt == 0) err = 1; else cnt--;
        end
        default:     val = 0;
      endcase
      we = (d[15:8] != 8'hFF);
      q_pc.push_back(pc); q_we.push_back(we); q_wa.push_back(d);
      q_wd.push_back(val); q_tag.push_back(rom_tag[pc[7:0]]);
      npc = pc + 1;
      if (we) m_ram[d[7:0]] = val;
      else case (d)
        A_ACC: acc_m = val;
        A_AND: acc_m = acc_m & val;
        A_OR:  acc_m = acc_m | val;
        A_XOR: acc_m = acc_m ^ val;
        A_ADD: begin e = {1'b0, acc_m} + {1'b0, val}; c = e[16]; acc_m = e[15:0]; end
        A_ADC: begin e = {1'b0, acc_m} + {1'b0, val} + 17'(c); c = e[16]; acc_m = e[15:0]; end
        A_SUB: begin e = {1'b0, acc_m} - {1'b0, val}; c = e[16]; acc_m = e[15:0]; end
        A_SBB: begin e = {1'b0, acc_m} - {1'b0, val} - 17'(c); c = e[16]; acc_m = e[15:0]; end
        A_SZ:  zv = val;
        A_SNZ: nzv = val;
        A_PC:  npc = val;
        A_REL: npc = pc + val;
        A_CALL: begin
          stk[sp] = pc + 1; sp = (sp + 1) % 16;
          if (cnt == 16) err = 1; else cnt++;
          npc = val;
        end
        A_HLT: halted = 1;
        default: ;
      endcase
      if (d[15:8] == 8'hFF && d <= A_SBB) z = (acc_m == 0);
      pc = npc;
    end
    m_acc = acc_m; m_err = err;
  endtask

  // monitor: pops one expected transfer per cycle, away from the rising edge
  always @(negedge clk) begin
    if (mon_on && rst_ni && !halt) begin
      if (q_pc.size() == 0) chk(0, "R2", "unexpected transfer at pc", 32'(imem_addr), 0);
      else begin
        logic [15:0] epc, ewa, ewd; bit ewe; string t;
        epc = q_pc.pop_front(); ewe = q_we.pop_front(); ewa = q_wa.pop_front();
        ewd = q_wd.pop_front(); t = q_tag.pop_front();
        chk(imem_addr == epc, t, "fetch address", 32'(imem_addr), 32'(epc));
        chk(dmem_we == ewe, t, "ram write enable", 32'(dmem_we), 32'(ewe));
        if (ewe) begin
          chk(dmem_waddr == ewa, t, "ram write address", 32'(dmem_waddr), 32'(ewa));
          chk(dmem_wdata == ewd, t, "moved value", 32'(dmem_wdata), 32'(ewd));
        end
      end
    end
  end

  task automatic run_prog();
    logic [15:0] pc_hold;
    int bad;
    rst_ni = 0; mon_on = 0;
    q_pc.delete(); q_we.delete(); q_wa.delete(); q_wd.delete(); q_tag.delete();
    @(posedge clk); #2;
    run_model();
    chk(imem_addr == 0, "R1", "reset pc", 32'(imem_addr), 0);
    chk(acc == 0, "R1", "reset acc", 32'(acc), 0);
    chk(halt == 0, "R1", "reset halt", 32'(halt), 0);
    chk(stk_err == 0, "R1", "reset stack error", 32'(stk_err), 0);
    mon_on = 1;
    @(posedge clk); #2 rst_ni = 1;
    for (int k = 0; k < 2000 && !halt; k++) @(posedge clk);
    if (!halt) chk(0, "R10", "watchdog, no halt", 0, 1);
    @(negedge clk);
    mon_on = 0;
    chk(q_pc.size() == 0, "R2", "transfers left unexecuted", 32'(q_pc.size()), 0);
    chk(acc == m_acc, "R3", "final accumulator", 32'(acc), 32'(m_acc));
    chk(stk_err == m_err, "R9", "stack error flag", 32'(stk_err), 32'(m_err));
    pc_hold = imem_addr;
    repeat (3) @(negedge clk);
    chk(imem_addr == pc_hold, "R10", "pc after halt", 32'(imem_addr), 32'(pc_hold));
    bad = 0;
    for (int i = 0; i < 256; i++) if (ram[i] !== m_ram[i]) bad++;
    chk(bad == 0, "R2", "ram words differing from model", 32'(bad), 0);
  endtask

  initial begin
    // program 1: ALU, flags, dead offsets, Z/NZ, halt
    clear_prog();
    cur_tag = "R2";  mv(16'h0040, 16'h0080);
    cur_tag = "R3";  mv(16'h0040, A_ACC); mv(16'h0041, A_AND); mv(A_ACC, 16'h0081);
                     mv(16'h0044, A_OR);  mv(A_ACC, 16'h0082);
                     mv(16'h0042, A_XOR); mv(A_ACC, 16'h0083);
    cur_tag = "R4";  mv(16'h0042, A_ACC); mv(16'h0001, A_ADD); mv(A_FLG, 16'h0084);
                     mv(A_ACC, 16'h0085); mv(16'h0000, A_ADC); mv(A_ACC, 16'h0086);
                     mv(A_FLG, 16'h0087); mv(16'h0002, A_SUB); mv(A_ACC, 16'h0088);
                     mv(16'h0000, A_SBB); mv(A_ACC, 16'h0089); mv(A_FLG, 16'h008A);
                     mv(16'h0043, A_ADD); mv(16'h0043, A_XOR); mv(16'h0001, A_AND);
                     mv(A_FLG, 16'h008B);
    cur_tag = "R11"; mv(16'h0005, 16'hFF20); mv(A_XOR, 16'h008C); mv(16'hFF30, 16'h008D);
                     mv(16'h0007, A_FLG); mv(A_FLG, 16'h008E); mv(A_ACC, 16'h008F);
    cur_tag = "R5";  mv(16'h0040, A_SZ); mv(16'h0044, A_SNZ); mv(16'h0000, A_ACC);
                     mv(A_SZ, 16'h0090); mv(A_SNZ, 16'h0091); mv(16'h0003, A_ACC);
                     mv(A_SZ, 16'h0092); mv(A_SNZ, 16'h0093);
    cur_tag = "R10"; mv(16'h0000, A_HLT); mv(16'h0040, 16'h0094);
    run_prog();
    chk(ram[8'h81] == 16'h0034, "R3", "AND result", 32'(ram[8'h81]), 32'h0034);
    chk(ram[8'h82] == 16'h0F3F, "R3", "OR result", 32'(ram[8'h82]), 32'h0F3F);
    chk(ram[8'h83] == 16'hF0C0, "R3", "XOR result", 32'(ram[8'h83]), 32'hF0C0);
    chk(ram[8'h84] == 16'h0003, "R4", "flags after ADD wrap", 32'(ram[8'h84]), 32'h3);
    chk(ram[8'h86] == 16'h0001, "R4", "ADC uses carry", 32'(ram[8'h86]), 32'h1);
    chk(ram[8'h88] == 16'hFFFF, "R4", "SUB borrow result", 32'(ram[8'h88]), 32'hFFFF);
    chk(ram[8'h89] == 16'hFFFE, "R4", "SBB uses borrow", 32'(ram[8'h89]), 32'hFFFE);
    chk(ram[8'h8B] == 16'h0003, "R4", "carry kept over AND", 32'(ram[8'h8B]), 32'h3);
    chk(ram[8'h8C] == 16'h0000, "R11", "write-only read", 32'(ram[8'h8C]), 0);
    chk(ram[8'h8E] == 16'h0003, "R11", "flags after ignored writes", 32'(ram[8'h8E]), 32'h3);
    chk(ram[8'h90] == 16'h1234, "R5", "Z read, zero set", 32'(ram[8'h90]), 32'h1234);
    chk(ram[8'h91] == 16'h1234, "R5", "NZ read, zero set", 32'(ram[8'h91]), 32'h1234);
    chk(ram[8'h93] == 16'h0F0F, "R5", "NZ read, zero clear", 32'(ram[8'h93]), 32'h0F0F);
    chk(ram[8'h94] == 16'h0000, "R10", "no write after halt", 32'(ram[8'h94]), 0);

    // program 2: jumps, relative jumps, calls, conditional flow
    clear_prog();
    cur_tag = "R6"; put(0, A_PC, 16'h00A0); put(1, 16'h0005, A_PC); put(2, 16'h0040, 16'h00A1);
    cur_tag = "R7"; put(5, 16'h0003, A_REL);
    cur_tag = "R8"; put(8, 16'h0014, A_CALL); put(9, A_ACC, 16'h00A2);
                    put(20, 16'h0044, A_ACC); put(21, 16'h0016, A_CALL);
                    put(22, A_RET, 16'h00A3); put(23, A_RET, A_PC);
    cur_tag = "R5"; put(10, 16'h000F, A_SZ); put(11, 16'h000D, A_SNZ);
                    put(12, 16'h0000, A_ACC); put(13, A_SZ, A_PC);
                    put(15, 16'h0003, A_ACC); put(16, 16'h0019, A_SNZ); put(17, A_SZ, A_PC);
    cur_tag = "R7"; put(25, 16'h0042, A_REL); put(24, 16'h001B, A_PC);
    run_prog();
    chk(ram[8'hA0] == 16'h0000, "R6", "pc read value", 32'(ram[8'hA0]), 0);
    chk(ram[8'hA1] == 16'h0000, "R6", "no delay slot", 32'(ram[8'hA1]), 0);
    chk(ram[8'hA2] == 16'h0F0F, "R8", "return to caller", 32'(ram[8'hA2]), 32'h0F0F);
    chk(ram[8'hA3] == 16'h0016, "R8", "popped return address", 32'(ram[8'hA3]), 32'h16);

    // program 3: seventeen pushes wrap the stack, then one pop
    clear_prog();
    cur_tag = "R9";
    for (int i = 0; i < 17; i++) mv(16'(i + 1), A_CALL);
    mv(A_RET, 16'h00B0);
    run_prog();
    chk(stk_err == 1'b1, "R9", "overflow flag", 32'(stk_err), 1);
    chk(ram[8'hB0] == 16'h0011, "R9", "entry after wrap", 32'(ram[8'hB0]), 32'h11);

    // program 4: pop on empty stack, popped value discarded
    clear_prog();
    cur_tag = "R9"; mv(A_RET, 16'hFF40);
    run_prog();
    chk(stk_err == 1'b1, "R9", "underflow flag", 32'(stk_err), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule